// File: doc/BRIEF.md
# CEC Frame Receiver

This block listens to a single-wire, open-drain consumer-electronics control bus (the line used by HDMI CEC) and turns its pulse-width-coded traffic into ten-bit receive blocks. The incoming level is synchronised and passed through a glitch filter with separate hold times for each level. A start-bit detector checks the low time and the full period of the opening pulse. Bits are then decoded by sampling the filtered line a fixed number of ticks after each falling edge. Every block holds eight data bits (most significant first), an end-of-message bit and an acknowledge bit. Each block is latched into a receive buffer and announced by a one-cycle interrupt pulse.

All timing settings are counts of a slow sampling tick (`tickEn`). Software programs them while `rxEnable` is low, raises `rxEnable` to arm the receiver, and watches `busy` fall after disarming. When the first block of a frame names a destination whose bit is set in a 16-bit acceptance mask, the block pulls the line low in the acknowledge slot of every block of that frame. The destination 15 is the broadcast address and is never acknowledged this way. The acknowledge bit kept in the buffer is the level seen on the line, whoever drove it.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset `busy`, `cecPullLow`, all three interrupt outputs and `rxBuf` are 0. `busy` is 1 from the cycle after `rxEnable` rises. While `rxEnable` is 0, `busy`, `cecPullLow` and every interrupt stay 0 from the next cycle on, and line traffic produces no interrupts.
- R2: A start bit is accepted only if its filtered low time lies in [`cfgStartLowMin`, `cfgStartLowMax`] ticks and its falling-to-falling period lies in [`cfgStartPerMin`, `cfgStartPerMax`] ticks. Acceptance gives a one-cycle `irqStart` pulse. A pulse outside either window starts nothing.
- R3: A line level that lasts fewer ticks than `cfgNoiseLow` (for low) or `cfgNoiseHigh` (for high) is ignored and changes no decoded bit.
- R4: Each data bit begins on a falling edge and is sampled `cfgSamplePoint` ticks later, with low read as 0. After ten bits, `rxBuf` = {data[7:0] in bits 9:2, end-of-message in bit 1, acknowledge in bit 0}, and `irqBlock` pulses in the same cycle that `rxBuf` takes the new value.
- R5: Blocks keep arriving until one has end-of-message = 1. After that block, further pulses produce no block until a new valid start bit is seen.
- R6: Bit 0 of `rxBuf` is the acknowledge level sampled on the line (0 if any node pulled it low), not the value this block generated.
- R7: If the upper nibble of the first data byte (the destination) selects a set bit of `cfgAddrMask` and is not 15, `cecPullLow` asserts once per block, in the acknowledge slot, from that slot's falling edge until `cfgAckHold` ticks later. Otherwise `cecPullLow` never asserts.
- R8: Destination 15 (broadcast) is never acknowledged, even when mask bit 15 is set.
- R9: During bit reception, a falling-edge-to-falling-edge period outside [`cfgBitPerMin`, `cfgBitPerMax`] ticks, or a wait past `cfgBitPerMax` with no edge, gives a one-cycle `irqErr`, writes no buffer and abandons the frame.
- R10: `irqStart`, `irqBlock` and `irqErr` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Sampling tick strobe; all timing settings count these |
| rxEnable | input | 1 | Arms the receiver |
| cecIn | input | 1 | Raw bus level (asynchronous) |
| cfgAddrMask | input | 16 | Bit n set: accept and acknowledge logical address n |
| cfgNoiseHigh | input | CW | Minimum ticks for a high level to be believed |
| cfgNoiseLow | input | CW | Minimum ticks for a low level to be believed |
| cfgStartLowMin | input | CW | Shortest accepted start-bit low time |
| cfgStartLowMax | input | CW | Longest accepted start-bit low time |
| cfgStartPerMin | input | CW | Shortest accepted start-bit period |
| cfgStartPerMax | input | CW | Longest accepted start-bit period |
| cfgBitPerMin | input | CW | Shortest accepted data-bit period |
| cfgBitPerMax | input | CW | Longest accepted data-bit period |
| cfgSamplePoint | input | CW | Ticks from a bit's falling edge to its sample |
| cfgAckHold | input | CW | Ticks the acknowledge pull lasts |
| cecPullLow | output | 1 | Open-drain drive: 1 pulls the bus low |
| rxBuf | output | 10 | Last received block {data, end-of-message, acknowledge} |
| irqStart | output | 1 | Start bit accepted (pulse) |
| irqBlock | output | 1 | Block written to `rxBuf` (pulse) |
| irqErr | output | 1 | Bit-period error, frame dropped (pulse) |
| busy | output | 1 | Receiver armed |

## Verification
The bench sweeps all sixteen destinations against a mask that includes bit 15. A decoder that read the destination from the wrong nibble, or forgot the broadcast exclusion, would pull the acknowledge for the wrong frames. It would also store 0 where the line stayed high. The bench places start and bit periods exactly on and one tick outside every window. An off-by-one in the tick counter would accept a pulse it should reject, or raise `irqErr` on a legal frame. Frames are also sent with one-tick spikes inside both bit phases, which a filter without hold time would turn into cycle errors or flipped bits. Trailing pulses after an end-of-message block, and a frame with two non-final blocks, expose a receiver that stops too early or fails to stop.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int BLOCK_BITS = 10;
  localparam int IDX_W = $clog2(BLOCK_BITS);
  localparam logic [3:0] BCAST_ADDR = 4'hF;

  typedef enum logic [2:0] {
    S_OFF, S_WAIT, S_SLOW, S_SHIGH, S_BIT
  } rxState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic sample;
    logic blockDone;
    logic clearIdx;
    logic pullSet;
    logic pullRel;
  } rxStrobe_t;
endpackage

// File: rtl/cec_rx_dp.sv
module cec_rx_dp
  import cec_rx_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cecIn,
  input  logic [CW-1:0]     cfgNoiseHigh,
  input  logic [CW-1:0]     cfgNoiseLow,
  input  rxStrobe_t         stb,
  output logic              lineF,
  output logic              fallEv,
  output logic              riseEv,
  output logic [CW-1:0]     cnt,
  output logic [IDX_W-1:0]  bitIdx,
  output logic [8:0]        shiftReg,
  output logic [9:0]        rxBuf,
  output logic              pullLow
);
  localparam logic [CW-1:0] CNT_SAT = '1;

  logic [1:0]    syncQ;
  logic          syncLvl;
  logic [CW-1:0] glCnt;
  logic [CW:0]   glNext;
  logic [CW-1:0] holdThr;
  logic          lineFd;

  assign syncLvl = syncQ[1];
  assign holdThr = syncLvl ? cfgNoiseHigh : cfgNoiseLow;
  assign glNext  = {1'b0, glCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], cecIn};
  end

  // level filter: a new level must persist holdThr ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineF <= 1'b1;
      glCnt <= '0;
    end else if (syncLvl == lineF) begin
      glCnt <= '0;
    end else if (tickEn) begin
      if (glNext >= {1'b0, holdThr}) begin
        lineF <= syncLvl;
        glCnt <= '0;
      end else begin
        glCnt <= glNext[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineFd <= 1'b1;
    else       lineFd <= lineF;
  end
  assign fallEv = lineFd & ~lineF;
  assign riseEv = ~lineFd & lineF;

  // ticks since last falling edge, starting at 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (fallEv)                   cnt <= CW'(1);
    else if (tickEn && cnt != CNT_SAT) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx   <= '0;
      shiftReg <= '0;
      rxBuf    <= '0;
    end else if (stb.clearIdx) begin
      bitIdx <= '0;
    end else if (stb.sample) begin
      shiftReg <= {shiftReg[7:0], lineF};
      if (stb.blockDone) begin
        rxBuf  <= {shiftReg, lineF};
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pullLow <= 1'b0;
    else if (stb.pullSet) pullLow <= 1'b1;
    else if (stb.pullRel) pullLow <= 1'b0;
  end
endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              rxEnable,
  input  logic              lineF,
  input  logic              fallEv,
  input  logic              riseEv,
  input  logic [CW-1:0]     cnt,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [8:0]        shiftReg,
  input  logic [15:0]       cfgAddrMask,
  input  logic [CW-1:0]     cfgStartLowMin,
  input  logic [CW-1:0]     cfgStartLowMax,
  input  logic [CW-1:0]     cfgStartPerMin,
  input  logic [CW-1:0]     cfgStartPerMax,
  input  logic [CW-1:0]     cfgBitPerMin,
  input  logic [CW-1:0]     cfgBitPerMax,
  input  logic [CW-1:0]     cfgSamplePoint,
  input  logic [CW-1:0]     cfgAckHold,
  output rxStrobe_t         stb,
  output rxState_t          state,
  output logic              irqStart,
  output logic              irqBlock,
  output logic              irqErr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BITS - 1);
  localparam logic [IDX_W-1:0] DEST_IDX = IDX_W'(3);

  rxState_t   nxt;
  logic       startP, blockP, errP;
  logic       ackMe, firstBlk;
  logic [3:0] destAddr;

  assign destAddr = {shiftReg[2:0], lineF};

  always_comb begin
    nxt    = state;
    stb    = '0;
    startP = 1'b0;
    blockP = 1'b0;
    errP   = 1'b0;
    if (tickEn && cnt >= cfgAckHold) stb.pullRel = 1'b1;
    if (!rxEnable) begin
      nxt          = S_OFF;
      stb.pullRel  = 1'b1;
      stb.clearIdx = 1'b1;
    end else begin
      unique case (state)
        S_OFF:  nxt = S_WAIT;
        S_WAIT: if (fallEv) nxt = S_SLOW;
        S_SLOW: begin
          if (riseEv)
            nxt = (cnt >= cfgStartLowMin && cnt <= cfgStartLowMax) ? S_SHIGH : S_WAIT;
          else if (tickEn && cnt > cfgStartLowMax)
            nxt = S_WAIT;
        end
        S_SHIGH: begin
          if (fallEv) begin
            if (cnt >= cfgStartPerMin && cnt <= cfgStartPerMax) begin
              nxt          = S_BIT;
              startP       = 1'b1;
              stb.clearIdx = 1'b1;
            end else begin
              nxt = S_SLOW;
            end
          end else if (tickEn && cnt > cfgStartPerMax) begin
            nxt = S_WAIT;
          end
        end
        S_BIT: begin
          if (fallEv) begin
            if (cnt < cfgBitPerMin || cnt > cfgBitPerMax) begin
              errP = 1'b1; nxt = S_WAIT; stb.clearIdx = 1'b1; stb.pullRel = 1'b1;
            end else if (bitIdx == LAST_IDX && ackMe) begin
              stb.pullSet = 1'b1;
            end
          end else if (tickEn && cnt > cfgBitPerMax) begin
            errP = 1'b1; nxt = S_WAIT; stb.clearIdx = 1'b1; stb.pullRel = 1'b1;
          end else if (tickEn && cnt == cfgSamplePoint) begin
            stb.sample = 1'b1;
            if (bitIdx == LAST_IDX) begin
              stb.blockDone = 1'b1;
              blockP        = 1'b1;
              if (shiftReg[0]) nxt = S_WAIT;
            end
          end
        end
        default: nxt = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_OFF;
      irqStart <= 1'b0;
      irqBlock <= 1'b0;
      irqErr   <= 1'b0;
      ackMe    <= 1'b0;
      firstBlk <= 1'b0;
    end else begin
      state    <= nxt;
      irqStart <= startP;
      irqBlock <= blockP;
      irqErr   <= errP;
      if (startP) begin
        ackMe    <= 1'b0;
        firstBlk <= 1'b1;
      end else if (nxt == S_OFF) begin
        ackMe <= 1'b0;
      end else if (stb.sample && firstBlk && bitIdx == DEST_IDX) begin
        ackMe <= cfgAddrMask[destAddr] && (destAddr != BCAST_ADDR);
      end
      if (stb.blockDone) firstBlk <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          rxEnable,
  input  logic          cecIn,
  input  logic [15:0]   cfgAddrMask,
  input  logic [CW-1:0] cfgNoiseHigh,
  input  logic [CW-1:0] cfgNoiseLow,
  input  logic [CW-1:0] cfgStartLowMin,
  input  logic [CW-1:0] cfgStartLowMax,
  input  logic [CW-1:0] cfgStartPerMin,
  input  logic [CW-1:0] cfgStartPerMax,
  input  logic [CW-1:0] cfgBitPerMin,
  input  logic [CW-1:0] cfgBitPerMax,
  input  logic [CW-1:0] cfgSamplePoint,
  input  logic [CW-1:0] cfgAckHold,
  output logic          cecPullLow,
  output logic [9:0]    rxBuf,
  output logic          irqStart,
  output logic          irqBlock,
  output logic          irqErr,
  output logic          busy
);
  rxStrobe_t        stb;
  rxState_t         ctrlState;
  logic             lineF, fallEv, riseEv;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] bitIdx;
  logic [8:0]       shiftReg;

  cec_rx_dp #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cecIn(cecIn),
    .cfgNoiseHigh(cfgNoiseHigh), .cfgNoiseLow(cfgNoiseLow), .stb(stb),
    .lineF(lineF), .fallEv(fallEv), .riseEv(riseEv), .cnt(cnt),
    .bitIdx(bitIdx), .shiftReg(shiftReg), .rxBuf(rxBuf), .pullLow(cecPullLow)
  );

  cec_rx_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxEnable(rxEnable),
    .lineF(lineF), .fallEv(fallEv), .riseEv(riseEv), .cnt(cnt),
    .bitIdx(bitIdx), .shiftReg(shiftReg), .cfgAddrMask(cfgAddrMask),
    .cfgStartLowMin(cfgStartLowMin), .cfgStartLowMax(cfgStartLowMax),
    .cfgStartPerMin(cfgStartPerMin), .cfgStartPerMax(cfgStartPerMax),
    .cfgBitPerMin(cfgBitPerMin), .cfgBitPerMax(cfgBitPerMax),
    .cfgSamplePoint(cfgSamplePoint), .cfgAckHold(cfgAckHold),
    .stb(stb), .state(ctrlState),
    .irqStart(irqStart), .irqBlock(irqBlock), .irqErr(irqErr)
  );

  assign busy = (ctrlState != S_OFF);
endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk
  import cec_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       cecPullLow,
  input logic [9:0] rxBuf,
  input logic       irqStart,
  input logic       irqBlock,
  input logic       irqErr,
  input logic       busy,
  input rxState_t   ctrlState
);
  a_r1_disable_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!busy && !irqStart && !irqBlock && !irqErr && !cecPullLow));

  a_r2_start_enters_bits: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |-> (ctrlState == S_BIT));

  a_r4_buf_only_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    !irqBlock |-> $stable(rxBuf));

  a_r7_pull_needs_armed: assert property (@(posedge clk) disable iff (!rstN)
    cecPullLow |-> busy);

  a_r9_err_abandons: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |-> (ctrlState == S_WAIT && !irqBlock));

  a_r10_block_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqBlock |=> !irqBlock);

  a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |=> !irqStart);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqErr |=> !irqErr);
endmodule

bind cec_frame_rx cec_frame_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cecPullLow(cecPullLow),
  .rxBuf(rxBuf), .irqStart(irqStart), .irqBlock(irqBlock), .irqErr(irqErr),
  .busy(busy), .ctrlState(ctrlState)
);

// File: tb/cec_frame_rx_tb.sv
module cec_frame_rx_tb;
  localparam int CW = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, rxEnable, drv;
  logic cecIn, cecPullLow, irqStart, irqBlock, irqErr, busy;
  logic [9:0] rxBuf;
  logic [15:0] mask = 16'hA5C3;

  assign cecIn = drv & ~cecPullLow;

  cec_frame_rx #(.CW(CW)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(1'b1), .rxEnable(rxEnable), .cecIn(cecIn),
    .cfgAddrMask(mask), .cfgNoiseHigh(CW'(2)), .cfgNoiseLow(CW'(2)),
    .cfgStartLowMin(CW'(34)), .cfgStartLowMax(CW'(40)),
    .cfgStartPerMin(CW'(41)), .cfgStartPerMax(CW'(49)),
    .cfgBitPerMin(CW'(20)), .cfgBitPerMax(CW'(28)),
    .cfgSamplePoint(CW'(10)), .cfgAckHold(CW'(13)),
    .cecPullLow(cecPullLow), .rxBuf(rxBuf), .irqStart(irqStart),
    .irqBlock(irqBlock), .irqErr(irqErr), .busy(busy)
  );

  int nChk = 0, nBad = 0;
  int startCnt = 0, errCnt = 0, blkCnt = 0, pullCnt = 0;
  logic [9:0] blkLog [0:7];
  logic pullPrev = 1'b0;
  bit done = 1'b0;
  logic [7:0] fb [0:3];

  always @(negedge clk) begin
    if (irqStart) startCnt++;
    if (irqErr) errCnt++;
    if (irqBlock) begin
      if (blkCnt < 8) blkLog[blkCnt] = rxBuf;
      blkCnt++;
    end
    if (cecPullLow && !pullPrev) pullCnt++;
    pullPrev = cecPullLow;
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic sendBit(input bit v, input int per, input bit gl);
    int lowL = v ? 6 : 15;
    drv = 1'b0;
    if (gl && !v) begin
      repeat (7) @(negedge clk); drv = 1'b1;
      @(negedge clk); drv = 1'b0;
      repeat (7) @(negedge clk);
    end else begin
      repeat (lowL) @(negedge clk);
    end
    drv = 1'b1;
    if (gl) begin
      repeat (4) @(negedge clk); drv = 1'b0;
      @(negedge clk); drv = 1'b1;
      repeat (per - lowL - 5) @(negedge clk);
    end else begin
      repeat (per - lowL) @(negedge clk);
    end
  endtask

  task automatic sendStart(input int lowL, input int per);
    drv = 1'b0;
    repeat (lowL) @(negedge clk);
    drv = 1'b1;
    repeat (per - lowL) @(negedge clk);
  endtask

  // blocks from fb[], final one carries EOM; badAt selects a bit with period badPer
  task automatic sendBlocks(input int n, input int per, input bit otherAck, input bit gl,
                            input int badAt, input int badPer);
    int k = 0;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        sendBit(fb[b][i], (k == badAt) ? badPer : per, gl); k++;
      end
      sendBit(b == n - 1, (k == badAt) ? badPer : per, gl); k++;
      sendBit(!otherAck, (k == badAt) ? badPer : per, gl); k++;
    end
    repeat (80) @(negedge clk);
  endtask

  function automatic bit addressed(input logic [7:0] hdr);
    return mask[hdr[7:4]] && hdr[7:4] != 4'hF;
  endfunction

  // full-frame check: start count, block count, each buffer and pull episodes
  task automatic frameCheck(input string tag, input int n, input bit otherAck,
                            input int s0, input int b0, input int p0);
    bit acc = addressed(fb[0]);
    logic [9:0] expV;
    check(startCnt == s0 + 1, {tag, " R2 start seen"}, startCnt - s0, 1);
    check(blkCnt == b0 + n, {tag, " R5 block count"}, blkCnt - b0, n);
    for (int b = 0; b < n; b++) begin
      expV = {fb[b], (b == n - 1), (acc || otherAck) ? 1'b0 : 1'b1};
      if (b0 + b < 8)
        check(blkLog[b0 + b] == expV, {tag, " R4 R6 buffer"}, int'(blkLog[b0 + b]), int'(expV));
    end
    check(pullCnt - p0 == (acc ? n : 0), {tag, " R7 R8 ack pulls"}, pullCnt - p0, acc ? n : 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int s0, b0, p0, e0;
    rstN = 1'b0; rxEnable = 1'b0; drv = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cecPullLow && !irqStart && !irqBlock && !irqErr, "R1 reset outputs", busy, 0);
    check(rxBuf == 10'd0, "R1 reset rxBuf", int'(rxBuf), 0);
    rxEnable = 1'b1;
    @(negedge clk);
    check(busy, "R1 busy when armed", busy, 1);
    repeat (20) @(negedge clk);

    // destination sweep: R4 R6 R7 R8
    for (int d = 0; d < 16; d++) begin
      bit oth = d[0];
      fb[0] = {4'(d), 4'(d ^ 3)};
      fb[1] = 8'(d * 29 + 7);
      s0 = startCnt; b0 = blkCnt; p0 = pullCnt; e0 = errCnt;
      sendStart(37, 45);
      sendBlocks(2, 24, oth, 1'b0, -1, 0);
      frameCheck($sformatf("sweep d=%0d", d), 2, oth, s0, b0, p0);
      check(errCnt == e0, "R9 no error on legal frame", errCnt - e0, 0);
    end

    // three blocks then trailing pulses: R5
    fb[0] = 8'h4A; fb[1] = 8'h00; fb[2] = 8'hFF;
    s0 = startCnt; b0 = blkCnt; p0 = pullCnt;
    sendStart(37, 45);
    sendBlocks(3, 24, 1'b0, 1'b0, -1, 0);
    frameCheck("multi", 3, 1'b0, s0, b0, p0);
    b0 = blkCnt;
    for (int i = 0; i < 12; i++) sendBit(i[0], 24, 1'b0);
    repeat (80) @(negedge clk);
    check(blkCnt == b0, "R5 no block after EOM without start", blkCnt - b0, 0);

    // bit period window edges: R9
    fb[0] = 8'h1C; fb[1] = 8'h96;
    for (int t = 0; t < 4; t++) begin
      int bp = (t == 0) ? 20 : (t == 1) ? 28 : (t == 2) ? 19 : 29;
      bit ok = (t < 2);
      s0 = startCnt; b0 = blkCnt; e0 = errCnt; p0 = pullCnt;
      sendStart(37, 45);
      if (ok) sendBlocks(2, bp, 1'b0, 1'b0, -1, 0);
      else    sendBlocks(2, 24, 1'b0, 1'b0, 3, bp);
      check(errCnt - e0 == (ok ? 0 : 1), $sformatf("R9 period %0d error count", bp), errCnt - e0, ok ? 0 : 1);
      check(blkCnt - b0 == (ok ? 2 : 0), $sformatf("R9 period %0d blocks", bp), blkCnt - b0, ok ? 2 : 0);
      if (ok) frameCheck($sformatf("period %0d", bp), 2, 1'b0, s0, b0, p0);
    end

    // start window edges: R2
    fb[0] = 8'h0E;
    for (int t = 0; t < 8; t++) begin
      int lw = (t == 0) ? 34 : (t == 1) ? 40 : (t == 2) ? 33 : (t == 3) ? 41 : 37;
      int pr = (t == 4) ? 41 : (t == 5) ? 49 : (t == 6) ? 40 : (t == 7) ? 50 : 45;
      bit ok = (t == 0 || t == 1 || t == 4 || t == 5);
      s0 = startCnt; b0 = blkCnt;
      sendStart(lw, pr);
      sendBlocks(1, 24, 1'b0, 1'b0, -1, 0);
      check(startCnt - s0 == (ok ? 1 : 0), $sformatf("R2 start low=%0d per=%0d", lw, pr), startCnt - s0, ok ? 1 : 0);
      check(blkCnt - b0 == (ok ? 1 : 0), $sformatf("R2 blocks low=%0d per=%0d", lw, pr), blkCnt - b0, ok ? 1 : 0);
    end

    // glitches: R3
    s0 = startCnt;
    for (int i = 0; i < 10; i++) begin
      drv = 1'b0; @(negedge clk); drv = 1'b1; repeat (6) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check(startCnt == s0, "R3 idle spikes ignored", startCnt - s0, 0);
    fb[0] = 8'h2B; fb[1] = 8'h5D;
    s0 = startCnt; b0 = blkCnt; p0 = pullCnt; e0 = errCnt;
    sendStart(37, 45);
    sendBlocks(2, 24, 1'b0, 1'b1, -1, 0);
    frameCheck("glitch", 2, 1'b0, s0, b0, p0);
    check(errCnt == e0, "R3 spikes cause no error", errCnt - e0, 0);

    // disarmed: R1
    rxEnable = 1'b0;
    @(negedge clk);
    check(!busy, "R1 busy drops", busy, 0);
    fb[0] = 8'h3C; fb[1] = 8'h11;
    s0 = startCnt; b0 = blkCnt; p0 = pullCnt;
    sendStart(37, 45);
    sendBlocks(2, 24, 1'b0, 1'b0, -1, 0);
    check(startCnt == s0 && blkCnt == b0 && pullCnt == p0, "R1 disarmed silent",
          (startCnt - s0) + (blkCnt - b0) + (pullCnt - p0), 0);
    rxEnable = 1'b1;
    repeat (3) @(negedge clk);
    s0 = startCnt; b0 = blkCnt; p0 = pullCnt;
    sendStart(37, 45);
    sendBlocks(2, 24, 1'b0, 1'b0, -1, 0);
    frameCheck("rearmed R1", 2, 1'b0, s0, b0, p0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule